// File: doc/BRIEF.md
# Phase Detector with Lock Indicator

This block compares two divided edge streams, the reference and the feedback, and tells which one arrived first. Each rising edge arms a correction pulse. A reference edge that comes first drives `up_n` low, a feedback edge that comes first drives `dn_n` low, and the pulse stays low until the other edge arrives. When both pulses are armed, both are released one sampling-clock cycle later. Both pulse outputs are active low.

The signal `pump_any` is the NAND of the two active-low pulses, so it is high whenever any correction is in progress. A counter filters this signal in place of an external RC network. Each reference edge that passes without an over-wide correction pulse adds one to the count. Once the count reaches the programmed number of periods, `lock_ind` is raised. A correction run that lasts longer than `WIDE_LIMIT` sampling cycles clears the count at once. Both divided inputs are resynchronised to `clk`, and only their rising edges have any effect.

Top module: `phase_lock_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `up_n` and `dn_n` are high after that edge and `lock_ind` is low.
- R2: A reference edge that leads the feedback edge by d sampling cycles gives an `up_n` low pulse of d+1 cycles and a `dn_n` low pulse of exactly 1 cycle, both within the same correction run.
- R3: A feedback edge that leads the reference edge by d cycles gives a `dn_n` low pulse of d+1 cycles and an `up_n` low pulse of 1 cycle.
- R4: When both pulses are low in the same cycle, at least one of them is high in the next cycle. Edges that arrive in the same cycle give a one-cycle low pulse on both outputs.
- R5: `pump_any` is high exactly when `up_n` or `dn_n` is low.
- R6: `lock_ind` goes high once `lock_periods` (nonzero) consecutive reference edges have passed without an over-wide run. A `lock_periods` of 0 never declares lock.
- R7: A run in which `pump_any` stays high for more than `WIDE_LIMIT` consecutive cycles clears the count, and `lock_ind` is low from the next cycle on.
- R8: A run of exactly `WIDE_LIMIT` cycles does not clear the count.
- R9: A missing feedback edge holds `up_n` low across later reference edges until a feedback edge arrives, and lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst | input | 1 | synchronous active-high reset |
| ref_div | input | 1 | divided reference signal |
| fb_div | input | 1 | divided feedback signal |
| lock_periods | input | CNT_W | good reference periods required for lock |
| up_n | output | 1 | active-low pulse, reference leads |
| dn_n | output | 1 | active-low pulse, feedback leads |
| pump_any | output | 1 | NAND of `up_n` and `dn_n` |
| lock_ind | output | 1 | high when locked, low when out of lock |

## Verification
The pulse checks use reference-lead and feedback-lead offsets of 1 to 4 cycles, plus coincident edges. These separate the polarity assignment (R2, R3) from the one-cycle mutual release (R4). The offsets of 3 and 4 sit on either side of the width threshold, which shows that a run of exactly the limit is kept (R8) and one cycle more clears the count (R7). Runs of aligned periods show the count reaching the lock target (R6). Reference edges with no feedback edge check that lock is lost through frequency error (R9).

// File: rtl/pld_pkg.sv
package pld_pkg;

    // Pair of correction requests, active high inside the block.
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    // Saturating increment used by the run and period counters.
    function automatic int unsigned sat_step(input int unsigned v, input int unsigned cap);
        return (v >= cap) ? cap : v + 1;
    endfunction

endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], din};
    end

    // Rising edge on the last synchroniser stage pair.
    assign rise = sh[STAGES-2] & ~sh[STAGES-1];
endmodule

// File: rtl/pld_pfd.sv
module pld_pfd
    import pld_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pump_t hit,
    output pump_t act
);
    pump_t st;

    always_ff @(posedge clk) begin
        if (rst)                 st <= '0;
        else if (st.up && st.dn) st <= hit;              // one-cycle mutual release
        else                     st <= pump_t'(st | hit);
    end

    assign act = st;
endmodule

// File: rtl/pld_lock_filter.sv
module pld_lock_filter
    import pld_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WIDE_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic             pump_any,
    input  logic [CNT_W-1:0] lock_periods,
    output logic             lock
);
    localparam int RUN_W   = $clog2(WIDE_LIMIT + 1);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [RUN_W-1:0] run_cnt;
    logic [CNT_W-1:0] good_cnt;
    logic             over;

    assign over = pump_any && (int'(run_cnt) >= WIDE_LIMIT);

    always_ff @(posedge clk) begin
        if (rst)           run_cnt <= '0;
        else if (pump_any) run_cnt <= RUN_W'(sat_step(int'(run_cnt), WIDE_LIMIT));
        else               run_cnt <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst)           good_cnt <= '0;
        else if (over)     good_cnt <= '0;
        else if (ref_rise) good_cnt <= CNT_W'(sat_step(int'(good_cnt), CNT_MAX));
    end

    assign lock = (lock_periods != '0) && (good_cnt >= lock_periods);
endmodule

// File: rtl/phase_lock_detect.sv
module phase_lock_detect
    import pld_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WIDE_LIMIT  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_div,
    input  logic             fb_div,
    input  logic [CNT_W-1:0] lock_periods,
    output logic             up_n,
    output logic             dn_n,
    output logic             pump_any,
    output logic             lock_ind
);
    logic [1:0] raw;
    logic [1:0] rise;
    pump_t      hit;
    pump_t      act;

    assign raw = {fb_div, ref_div};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        pld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .rise(rise[g])
        );
    end

    assign hit.up = rise[0];
    assign hit.dn = rise[1];

    pld_pfd u_pfd (
        .clk(clk),
        .rst(rst),
        .hit(hit),
        .act(act)
    );

    assign up_n     = ~act.up;
    assign dn_n     = ~act.dn;
    assign pump_any = act.up | act.dn;

    pld_lock_filter #(.CNT_W(CNT_W), .WIDE_LIMIT(WIDE_LIMIT)) u_filt (
        .clk         (clk),
        .rst         (rst),
        .ref_rise    (rise[0]),
        .pump_any    (pump_any),
        .lock_periods(lock_periods),
        .lock        (lock_ind)
    );
endmodule

// File: rtl/pld_chk.sv
module pld_chk #(
    parameter int WIDE_LIMIT = 4
) (
    input logic clk,
    input logic rst,
    input logic up_n,
    input logic dn_n,
    input logic pump_any,
    input logic lock_ind
);
    int chk_run;

    always_ff @(posedge clk) begin
        if (rst)           chk_run <= 0;
        else if (pump_any) chk_run <= (chk_run >= WIDE_LIMIT) ? WIDE_LIMIT : chk_run + 1;
        else               chk_run <= 0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (up_n && dn_n && !lock_ind));

    assert_mutual_release_R4: assert property (@(posedge clk) disable iff (rst)
        (!up_n && !dn_n) |=> (up_n || dn_n));

    assert_nand_R5: assert property (@(posedge clk) disable iff (rst)
        pump_any == (!up_n || !dn_n));

    assert_wide_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (pump_any && chk_run >= WIDE_LIMIT) |=> !lock_ind);

    assert_lock_rise_clean_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_ind) |-> !$past(pump_any && chk_run >= WIDE_LIMIT));
endmodule

bind phase_lock_detect pld_chk #(.WIDE_LIMIT(WIDE_LIMIT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .up_n    (up_n),
    .dn_n    (dn_n),
    .pump_any(pump_any),
    .lock_ind(lock_ind)
);

// File: tb/phase_lock_detect_test.sv
module phase_lock_detect_test;
    localparam int CNT_W = 8;
    localparam int LIM   = 4;
    localparam int T     = 5;

    logic clk = 0;
    logic rst = 1;
    logic ref_div = 0;
    logic fb_div = 0;
    logic [CNT_W-1:0] lock_periods = CNT_W'(T);
    logic up_n, dn_n, pump_any, lock_ind;

    int checks = 0;
    int fails = 0;
    bit mon_en = 0;
    bit done = 0;
    int model_cnt = 0;

    typedef struct {
        int    uw;
        int    dw;
        string req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    phase_lock_detect #(.CNT_W(CNT_W), .WIDE_LIMIT(LIM)) uut (
        .clk(clk), .rst(rst), .ref_div(ref_div), .fb_div(fb_div),
        .lock_periods(lock_periods), .up_n(up_n), .dn_n(dn_n),
        .pump_any(pump_any), .lock_ind(lock_ind)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measures each correction run and compares against the queue.
    int  mu = 0, md = 0;
    bit  in_run = 0;
    always @(negedge clk) begin
        if (!rst && mon_en) begin
            check(pump_any == (!up_n || !dn_n), "R5", pump_any, (!up_n || !dn_n));
            if (pump_any) begin
                in_run = 1;
                if (!up_n) mu++;
                if (!dn_n) md++;
            end else if (in_run) begin
                if (q.size() == 0) begin
                    check(0, "R2/R3 unexpected run", mu, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(mu == e.uw, {e.req, " up width"}, mu, e.uw);
                    check(md == e.dw, {e.req, " dn width"}, md, e.dw);
                end
                in_run = 0; mu = 0; md = 0;
            end
        end
    end

    // kind: 0 ref leads, 1 fb leads, 2 aligned
    task automatic period(input int kind, input int d, input string req);
        exp_t e;
        int w;
        w = (kind == 2) ? 1 : d + 1;
        e.uw = (kind == 1) ? 1 : w;
        e.dw = (kind == 0) ? 1 : w;
        e.req = req;
        q.push_back(e);
        @(negedge clk);
        if (kind == 2) begin ref_div = 1; fb_div = 1; end
        else if (kind == 0) ref_div = 1;
        else fb_div = 1;
        repeat (d) @(negedge clk);
        ref_div = 1; fb_div = 1;
        repeat (4) @(negedge clk);
        ref_div = 0; fb_div = 0;
        repeat (12) @(negedge clk);
        if (w > LIM) model_cnt = 0;
        else model_cnt++;
        check(lock_ind == (model_cnt >= T), (w > LIM) ? "R7 lock" : "R6 lock",
              lock_ind, (model_cnt >= T));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(up_n == 1 && dn_n == 1, "R1 pulses", {up_n, dn_n}, 3);
        check(lock_ind == 0, "R1 lock", lock_ind, 0);
        rst = 0;
        mon_en = 1;
        @(negedge clk);

        period(0, 1, "R2");
        period(1, 2, "R3");
        period(2, 0, "R4");
        period(0, 3, "R8");
        period(1, 3, "R8");          // fifth good period: lock
        period(0, 4, "R7");          // over-wide run clears
        period(1, 4, "R7");
        repeat (4) period(2, 0, "R4");
        period(1, 1, "R3");          // T-th good period again: lock

        // R9: reference edges with no feedback edge
        repeat (4) @(negedge clk);
        mon_en = 0;
        repeat (3) begin
            ref_div = 1; repeat (5) @(negedge clk);
            ref_div = 0; repeat (5) @(negedge clk);
        end
        check(up_n == 0, "R9 up held", up_n, 0);
        check(lock_ind == 0, "R9 lock lost", lock_ind, 0);
        fb_div = 1; repeat (4) @(negedge clk);
        check(up_n == 1 && dn_n == 1, "R9 released", {up_n, dn_n}, 3);
        fb_div = 0;

        // R6: zero target never locks
        lock_periods = '0;
        repeat (20) @(negedge clk);
        check(lock_ind == 0, "R6 zero target", lock_ind, 0);

        // R1: reset mid-pulse
        ref_div = 1; repeat (3) @(negedge clk);
        rst = 1; @(negedge clk);
        check(up_n == 1 && dn_n == 1 && lock_ind == 0, "R1 mid reset",
              {up_n, dn_n, lock_ind}, 6);
        check(q.size() == 0, "R2/R3 runs consumed", q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    fails++;
                    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule